// File: doc/BRIEF.md
# Secured Configuration Store With Signature

This block keeps the configuration image that a programmable logic core runs from, a one-bit seal that guards it, and a 64-bit signature word that the user may fill with any data. A host reaches all three through one word-wide command port with a valid/ready handshake. The whole image is also driven out in parallel, so the logic core sees every connection bit at all times.

The store follows the erase discipline of electrically erasable parts. The first word programmed after reset, or after a programming run has been closed, starts an automatic erase of the whole store. That erase holds the port busy for a fixed number of cycles, and the pending word is written once it ends. A dedicated erase command does the same without a pending word. After the seal is set, array reads return zero and raise a denied flag, but the signature can still be read. The only way to remove the seal is an erase, and an erase also wipes the array and the signature.

Top module: `cfg_secure_store`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the image is all zero, the seal is clear, the signature reads zero, busy is low and cmd_ready is high.
- R2: The first PROGRAM (op 0) after reset, or after the programming run has been closed, clears the array, signature and seal and then holds busy high for exactly ERASE_CYCLES cycles. When busy drops, the word appears in the image at position addr*WORD_W.
- R3: A PROGRAM accepted while a programming run is open writes its word at the accept edge, with no busy cycle.
- R4: READ (op 1) on an unsealed store answers one cycle after acceptance with rsp_valid high, the addressed word on rsp_data and rsp_denied low.
- R5: SEAL (op 2) sets the seal output. A READ accepted while the seal is set answers with rsp_data zero and rsp_denied high in its response cycle.
- R6: SIG_READ (op 3) returns signature word addr[1:0] whether or not the seal is set.
- R7: SIG_WRITE (op 4) stores wdata as signature word addr[1:0]; word 0 is bits 15:0 of the 64-bit signature.
- R8: ERASE (op 5) clears the array, the signature and the seal, and holds busy high for exactly ERASE_CYCLES cycles.
- R9: The seal can be cleared only by an erase. A PROGRAM that reaches a sealed store starts the automatic erase, so only the new word remains and the seal reads clear.
- R10: An accepted READ or SEAL closes the programming run, so the next PROGRAM triggers a fresh automatic erase.
- R11: cmd_ready is low in every cycle in which busy is high.
- R12: Op codes 6 and 7 are accepted but produce no response and change neither the image, the seal nor the signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when valid is high |
| cmd_op | input | 3 | Operation code (0 program, 1 read, 2 seal, 3 sig read, 4 sig write, 5 erase) |
| cmd_addr | input | 4 | Array word address, or signature word index in bits 1:0 |
| cmd_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid for one cycle |
| rsp_data | output | 16 | Read response data |
| rsp_denied | output | 1 | Array read refused because the store is sealed |
| busy | output | 1 | Erase in progress |
| secure | output | 1 | Seal state |
| cfg_image | output | 256 | Parallel configuration image to the logic core |

## Verification
Two functions can fall on the same clock edge. The last count of the automatic erase is also the edge that writes the deferred program word, and the seal takes effect in the cycle before a read that follows it at once. The bench provokes the first case by programming into a sealed store and into a closed run. It then checks that busy lasts exactly the erase length and that the image holds only the new word. For the second case it issues SEAL with READ right behind it and a signature read after that, and judges that the array read is refused while the signature read is answered.

// File: rtl/css_pkg.sv
// Shared types for the secured configuration store.
// Assumes a 3-bit operation field on the command port.
package css_pkg;
    typedef enum logic [2:0] {
        OP_PROG   = 3'd0,
        OP_READ   = 3'd1,
        OP_SEAL   = 3'd2,
        OP_SIG_RD = 3'd3,
        OP_SIG_WR = 3'd4,
        OP_ERASE  = 3'd5
    } css_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ERASE = 1'b1
    } css_state_e;
endpackage

// File: rtl/css_array.sv
// Configuration array: NUM_WORDS words of WORD_W bits, one write port,
// one combinational read port, and a flat copy of every cell.
// Assumes that clr and we are never high in the same cycle.
module css_array #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 16,
    parameter int ADDR_W    = $clog2(NUM_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [WORD_W-1:0]           rd_data,
    output logic [NUM_WORDS*WORD_W-1:0] image
);
    logic [WORD_W-1:0] cells [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        // Hold one word: cleared by reset or erase, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                word_q <= '0;
            else if (we && wr_addr == ADDR_W'(g))
                word_q <= wr_data;
        end
        assign cells[g] = word_q;
        assign image[g*WORD_W +: WORD_W] = word_q;
    end

    // Read port selects one word.
    always_comb rd_data = cells[rd_addr];

    // R8: an erase leaves every connection bit at zero.
    a_r8_array_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> image == '0);
endmodule

// File: rtl/css_sig.sv
// Signature storage: SIG_W bits held as SIG_W/WORD_W words, word 0 lowest.
// Assumes SIG_W is a whole multiple of WORD_W.
module css_sig #(
    parameter int WORD_W = 16,
    parameter int SIG_W  = 64,
    parameter int IDX_W  = $clog2(SIG_W / WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_data
);
    localparam int SIG_WORDS = SIG_W / WORD_W;

    logic [SIG_W-1:0] sig_flat;

    for (genvar g = 0; g < SIG_WORDS; g++) begin : g_sig
        logic [WORD_W-1:0] part_q;
        // Hold one signature word: cleared by reset or erase, loaded on write.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                part_q <= '0;
            else if (we && idx == IDX_W'(g))
                part_q <= wdata;
        end
        assign sig_flat[g*WORD_W +: WORD_W] = part_q;
    end

    // Read selects the indexed signature word.
    always_comb rd_data = sig_flat[idx*WORD_W +: WORD_W];

    // R8: an erase leaves the signature at zero.
    a_r8_sig_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> sig_flat == '0);
endmodule

// File: rtl/css_ctrl.sv
// Command controller: accepts commands, runs the timed erase, keeps the
// seal and the programming-run state, and forms read responses.
// Assumes ERASE_CYCLES >= 1.
module css_ctrl
    import css_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int ADDR_W       = 4,
    parameter int IDX_W        = 2,
    parameter int ERASE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              busy,
    output logic              secure,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_denied,
    input  logic [WORD_W-1:0] arr_rd_data,
    input  logic [WORD_W-1:0] sig_rd_data,
    output logic              erase_clr,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [WORD_W-1:0] arr_wdata,
    output logic              sig_we,
    output logic [IDX_W-1:0]  sig_idx
);
    localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

    css_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [WORD_W-1:0] pend_data_q;
    logic              open_q;
    logic              secure_q;
    css_op_e           op;
    logic              accept, start_erase, erase_done;

    // Decode the command and derive the control strobes.
    always_comb begin
        op          = css_op_e'(cmd_op);
        accept      = cmd_valid && state_q == ST_IDLE;
        start_erase = accept && (op == OP_ERASE || (op == OP_PROG && !open_q));
        erase_done  = state_q == ST_ERASE && cnt_q == '0;
        erase_clr   = start_erase;
        arr_we      = (accept && op == OP_PROG && open_q) || (erase_done && pend_q);
        arr_addr    = erase_done ? pend_addr_q : cmd_addr;
        arr_wdata   = erase_done ? pend_data_q : cmd_wdata;
        sig_we      = accept && op == OP_SIG_WR;
        sig_idx     = cmd_addr[IDX_W-1:0];
        cmd_ready   = state_q == ST_IDLE;
        busy        = state_q == ST_ERASE;
        secure      = secure_q;
    end

    // Erase sequencer with the deferred program word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            pend_data_q <= '0;
        end else if (start_erase) begin
            state_q     <= ST_ERASE;
            cnt_q       <= CNT_W'(ERASE_CYCLES - 1);
            pend_q      <= op == OP_PROG;
            pend_addr_q <= cmd_addr;
            pend_data_q <= cmd_wdata;
        end else if (state_q == ST_ERASE) begin
            if (erase_done) begin
                state_q <= ST_IDLE;
                pend_q  <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Seal and programming-run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secure_q <= 1'b0;
            open_q   <= 1'b0;
        end else if (start_erase) begin
            secure_q <= 1'b0;
            open_q   <= 1'b0;
        end else if (erase_done) begin
            open_q <= pend_q;
        end else if (accept && (op == OP_READ || op == OP_SEAL)) begin
            open_q <= 1'b0;
            if (op == OP_SEAL) secure_q <= 1'b1;
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_denied <= 1'b0;
            rsp_data   <= '0;
        end else begin
            rsp_valid  <= accept && (op == OP_READ || op == OP_SIG_RD);
            rsp_denied <= accept && op == OP_READ && secure_q;
            if (accept && op == OP_READ)
                rsp_data <= secure_q ? '0 : arr_rd_data;
            else if (accept && op == OP_SIG_RD)
                rsp_data <= sig_rd_data;
        end
    end

    // R5: a refused read carries zero data inside a valid response.
    a_r5_denied_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_denied |-> (rsp_valid && rsp_data == '0));

    // R8: the erase counter steps down by one each busy cycle.
    a_r8_erase_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && cnt_q != '0) |=>
            (state_q == ST_ERASE && cnt_q == $past(cnt_q) - 1'b1));

    // R9: the seal drops only when an erase begins.
    a_r9_seal_falls_on_erase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(secure_q) |-> state_q == ST_ERASE);

    // R4: a response only follows an accepted command.
    a_r4_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid && state_q == ST_IDLE));
endmodule

// File: rtl/cfg_secure_store.sv
// Top of the secured configuration store: ties the controller to the array
// and signature storage and exports the parallel image.
// Assumes a single clock domain and synchronous active-low reset.
module cfg_secure_store #(
    parameter int WORD_W       = 16,
    parameter int NUM_WORDS    = 16,
    parameter int SIG_W        = 64,
    parameter int ERASE_CYCLES = 8,
    localparam int ADDR_W      = $clog2(NUM_WORDS),
    localparam int IDX_W       = $clog2(SIG_W / WORD_W),
    localparam int IMG_W       = NUM_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_denied,
    output logic              busy,
    output logic              secure,
    output logic [IMG_W-1:0]  cfg_image
);
    logic              erase_clr, arr_we, sig_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [WORD_W-1:0] arr_wdata, arr_rd_data, sig_rd_data;
    logic [IDX_W-1:0]  sig_idx;

    css_ctrl #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_ready(cmd_ready), .busy(busy), .secure(secure),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_denied(rsp_denied),
        .arr_rd_data(arr_rd_data), .sig_rd_data(sig_rd_data),
        .erase_clr(erase_clr), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .sig_we(sig_we), .sig_idx(sig_idx)
    );

    css_array #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .clr(erase_clr), .we(arr_we),
        .wr_addr(arr_addr), .wr_data(arr_wdata), .rd_addr(cmd_addr),
        .rd_data(arr_rd_data), .image(cfg_image)
    );

    css_sig #(.WORD_W(WORD_W), .SIG_W(SIG_W), .IDX_W(IDX_W)) u_sig (
        .clk(clk), .rst_n(rst_n), .clr(erase_clr), .we(sig_we),
        .idx(sig_idx), .wdata(cmd_wdata), .rd_data(sig_rd_data)
    );
endmodule

// File: tb/cfg_secure_store_tb.sv
// Scoreboard bench: driver tasks keep a model of the store and queue the
// expected read responses; a monitor pops and compares them.
module cfg_secure_store_tb;
    localparam int W = 16, N = 16, EC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = '0;
    logic [3:0]    cmd_addr = '0;
    logic [W-1:0]  cmd_wdata = '0;
    logic          rsp_valid, rsp_denied, busy, secure;
    logic [W-1:0]  rsp_data;
    logic [N*W-1:0] cfg_image;

    int n_cmp = 0, n_bad = 0;
    logic [W:0]     exp_q [$];
    logic [N*W-1:0] m_img = '0;
    logic [63:0]    m_sig = '0;
    logic           m_seal = 1'b0, m_open = 1'b0;

    cfg_secure_store #(.WORD_W(W), .NUM_WORDS(N), .SIG_W(64), .ERASE_CYCLES(EC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_denied(rsp_denied),
        .busy(busy), .secure(secure), .cfg_image(cfg_image)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [N*W-1:0] act, logic [N*W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare every response against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected response", {rsp_denied, rsp_data}, '0);
                n_cmp--;
                if ({rsp_denied, rsp_data} == '0) begin n_cmp++; n_bad++;
                    $display("FAIL R12: actual response expected none"); end
            end else begin
                logic [W:0] e;
                e = exp_q.pop_front();
                check("R4/R5/R6 response", {rsp_denied, rsp_data}, e);
            end
        end
    end

    // Drive one command; returns at the falling edge after acceptance.
    task automatic issue(logic [2:0] op, logic [3:0] addr, logic [W-1:0] data);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Count busy cycles, checking R11 in each.
    task automatic expect_erase(string req);
        int n = 0;
        bit ready_seen = 0;
        while (busy) begin
            n++;
            if (cmd_ready) ready_seen = 1;
            @(negedge clk);
        end
        check({req, " busy length"}, n, EC);
        check("R11 ready low while busy", ready_seen, 0);
    endtask

    task automatic model_erase();
        m_img = '0; m_sig = '0; m_seal = 1'b0; m_open = 1'b0;
    endtask

    task automatic prog(logic [3:0] a, logic [W-1:0] d, string req);
        bit er = !m_open;
        issue(3'd0, a, d);
        if (er) begin model_erase(); expect_erase(req); end
        else check("R3 no busy on open run", busy, 0);
        m_img[a*W +: W] = d; m_open = 1'b1;
        check({req, " image"}, cfg_image, m_img);
    endtask

    task automatic rd(logic [3:0] a);
        exp_q.push_back({m_seal, m_seal ? 16'h0 : m_img[a*W +: W]});
        m_open = 1'b0;
        issue(3'd1, a, '0);
    endtask

    task automatic sig_rd(logic [1:0] i);
        exp_q.push_back({1'b0, m_sig[i*W +: W]});
        issue(3'd3, {2'b00, i}, '0);
    endtask

    task automatic sig_wr(logic [1:0] i, logic [W-1:0] d);
        m_sig[i*W +: W] = d;
        issue(3'd4, {2'b00, i}, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 image", cfg_image, '0);
        check("R1 seal", secure, 0);
        check("R1 busy", busy, 0);
        check("R1 ready", cmd_ready, 1);
        sig_rd(0);
        // R2: first program erases then writes
        prog(4'd3, 16'hA5A5, "R2");
        // R3: open run writes immediately
        prog(4'd7, 16'h1234, "R3");
        // R4: unsealed reads
        rd(4'd3);
        rd(4'd0);
        // R10: read closed the run, so this program erases again
        prog(4'd5, 16'hBEEF, "R10");
        // R7: signature writes then reads
        sig_wr(0, 16'h1111); sig_wr(1, 16'h2222); sig_wr(2, 16'h3333); sig_wr(3, 16'h4444);
        sig_rd(2); sig_rd(0);
        // R5: seal then immediate read is refused
        m_seal = 1'b1; m_open = 1'b0;
        issue(3'd2, '0, '0);
        check("R5 seal set", secure, 1);
        rd(4'd5);
        // R6: signature stays readable under the seal
        sig_rd(1);
        // R12: unused op codes have no effect
        issue(3'd6, 4'd5, 16'hFFFF);
        issue(3'd7, 4'd2, 16'hFFFF);
        repeat (2) @(negedge clk);
        check("R12 image unchanged", cfg_image, m_img);
        check("R12 seal unchanged", secure, 1);
        sig_rd(3);
        // R9: program into sealed store erases everything first
        prog(4'd1, 16'h0F0F, "R9");
        check("R9 seal cleared", secure, 0);
        sig_rd(3);
        // R8: explicit erase
        sig_wr(2, 16'h7777);
        issue(3'd5, '0, '0);
        model_erase();
        expect_erase("R8");
        check("R8 image", cfg_image, '0);
        check("R8 seal", secure, 0);
        sig_rd(2);
        repeat (4) @(negedge clk);
        check("R4 queue drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule